// File: doc/BRIEF.md
# Three-State 16-Bit Multicycle CPU Core

This block is a compact multicycle processor core. It presents a 12-bit program counter on an instruction-fetch address output and reads a 16-bit instruction word back from an external instruction memory through a combinational read. A three-state controller steps through reset, load and execute. In load, the fetched word is captured into an instruction register. In execute, the captured operation runs and the program counter moves on.

An instruction word carries a 4-bit operation code in bits [15:12] and a 12-bit address field in bits [11:0]. Three operation codes copy a word from the internal read-only data store into register A, B or C. One operation code jumps to the address field. The other twelve operation codes run the mode-selected ALU on A and B and write the result into C. Bit 15 selects arithmetic (0) or logic (1). The three data registers and the program counter are driven out on observation ports.

Top module: `mc16_core`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the program counter, the instruction register and registers A, B and C to 0, and puts the controller in its reset state. While the controller is in the reset state, no register changes, whatever word is on the instruction input.
- R2: After rst is released, the controller spends one cycle in the reset state and then alternates load and execute, so each instruction takes exactly two cycles. imemAddr equals the program counter. The register and PC outputs change only at the edge that ends the execute cycle.
- R3: The instruction register captures imemData only at the edge that ends the load cycle. Bits [15:12] are the operation code and bits [11:0] are the address field. A change of imemData during the execute cycle has no effect on the result.
- R4: Operation code 4'b0100 loads A, 4'b0101 loads B and 4'b0110 loads C with the data-store word at the address field. The other registers are unchanged and the PC increments by one.
- R5: Operation code 4'b0111 sets the PC to the address field and leaves A, B and C unchanged.
- R6: Arithmetic codes write C and increment the PC, with the result taken modulo 2^16: 4'b0000 gives A+B, 4'b0001 gives the low 16 bits of A*B, 4'b0010 gives A-B, and 4'b0011 gives the unsigned quotient A/B. When B is 0, the quotient result is 16'hFFFF. A and B are unchanged.
- R7: Logic codes write C and increment the PC: 4'b1000 AND, 4'b1001 OR, 4'b1010 NAND, 4'b1011 NOR, 4'b1100 NOT A, 4'b1101 NOT B, 4'b1110 XOR, 4'b1111 XNOR.
- R8: The PC is 12 bits wide and increments from 12'hFFF to 12'h000.
- R9: The data-store word at address a is the low 16 bits of a*16'h9E37, with a zero-extended. Address 0 therefore holds 0.
- R10: A reset asserted during a load or an execute cycle takes effect at the next edge, and the interrupted instruction leaves no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imemAddr | output | 12 | Instruction fetch address (program counter) |
| imemData | input | 16 | Instruction word read back from instruction memory |
| regA | output | 16 | Register A contents |
| regB | output | 16 | Register B contents |
| regC | output | 16 | Register C contents |
| pcOut | output | 12 | Program counter contents |

## Verification
The hardest conditions to reach from the ports are the ones that depend on operand values or on the address reached. A divide by a zero B needs the word at data-store address 0 loaded into B. The PC wrap needs the PC to sit at 12'hFFF, which a run of increments from zero would take thousands of instructions to reach. Directed sequences load both operands from address 0 to force the zero divisor, and jump to 12'hFFE and 12'hFFF before non-jump instructions to cross the wrap. A reset is also dropped into the middle of an execute cycle. Several hundred random instruction words then mix jumps, loads and all twelve ALU codes against a bench model, and the instruction input is scrambled during every execute cycle.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_LOAD  = 2'd1,
    ST_EXEC  = 2'd2
  } ctl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic irLoad;
    logic wrA;
    logic wrB;
    logic wrC;
    logic selAlu;
    logic pcInc;
    logic pcJump;
  } dp_strobe_t;

  localparam logic [3:0] OP_LDA = 4'b0100;
  localparam logic [3:0] OP_LDB = 4'b0101;
  localparam logic [3:0] OP_LDC = 4'b0110;
  localparam logic [3:0] OP_JMP = 4'b0111;

endpackage

// File: rtl/mc16_alu.sv
module mc16_alu #(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  logic [2*W-1:0] prod;
  logic [W-1:0]   arithY;
  logic [W-1:0]   logicY;

  always_comb prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};

  // mode 0: arithmetic
  always_comb begin
    case (op[2:0])
      3'b000:  arithY = a + b;
      3'b001:  arithY = prod[W-1:0];
      3'b010:  arithY = a - b;
      3'b011:  arithY = (b == '0) ? '1 : a / b;
      default: arithY = '0;
    endcase
  end

  // mode 1: bitwise logic
  always_comb begin
    case (op[2:0])
      3'b000:  logicY = a & b;
      3'b001:  logicY = a | b;
      3'b010:  logicY = ~(a & b);
      3'b011:  logicY = ~(a | b);
      3'b100:  logicY = ~a;
      3'b101:  logicY = ~b;
      3'b110:  logicY = a ^ b;
      default: logicY = ~(a ^ b);
    endcase
  end

  assign y = op[3] ? logicY : arithY;

endmodule

// File: rtl/mc16_dstore.sv
module mc16_dstore #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter logic [DW-1:0] MULT = 16'h9E37
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rdata
);

  localparam int PAD = DW - AW;

  logic [DW-1:0] addrExt;

  // contents are a fixed product of the address, so no storage array
  assign addrExt = {{PAD{1'b0}}, addr};
  assign rdata   = addrExt * MULT;

endmodule

// File: rtl/mc16_ctrl.sv
module mc16_ctrl
  import mc16_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output dp_strobe_t      strobe
);

  ctl_state_e state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RESET;
    else     state <= stateNext;
  end

  always_comb begin
    case (state)
      ST_RESET: stateNext = ST_LOAD;
      ST_LOAD:  stateNext = ST_EXEC;
      default:  stateNext = ST_LOAD;
    endcase
  end

  always_comb begin
    strobe = '0;
    case (state)
      ST_LOAD: strobe.irLoad = 1'b1;
      ST_EXEC: begin
        case (opcode)
          OP_LDA: begin strobe.wrA = 1'b1; strobe.pcInc = 1'b1; end
          OP_LDB: begin strobe.wrB = 1'b1; strobe.pcInc = 1'b1; end
          OP_LDC: begin strobe.wrC = 1'b1; strobe.pcInc = 1'b1; end
          OP_JMP: strobe.pcJump = 1'b1;
          default: begin
            strobe.wrC    = 1'b1;
            strobe.selAlu = 1'b1;
            strobe.pcInc  = 1'b1;
          end
        endcase
      end
      default: strobe = '0;
    endcase
  end

  a_r1_reset_enters_reset: assert property (@(posedge clk)
    rst |=> state == ST_RESET);

  a_r2_reset_then_load: assert property (@(posedge clk) disable iff (rst)
    state == ST_RESET |=> state == ST_LOAD);

  a_r2_load_then_exec: assert property (@(posedge clk) disable iff (rst)
    state == ST_LOAD |=> state == ST_EXEC);

  a_r2_exec_then_load: assert property (@(posedge clk) disable iff (rst)
    state == ST_EXEC |=> state == ST_LOAD);

  a_r5_pc_single_source: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.pcInc, strobe.pcJump}));

endmodule

// File: rtl/mc16_datapath.sv
module mc16_datapath
  import mc16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int OP_W   = 4,
  localparam int INSTR_W = OP_W + ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  dp_strobe_t         strobe,
  input  logic [INSTR_W-1:0] imemData,
  output logic [OP_W-1:0]    opcode,
  output logic [ADDR_W-1:0]  pc,
  output logic [DATA_W-1:0]  regA,
  output logic [DATA_W-1:0]  regB,
  output logic [DATA_W-1:0]  regC
);

  logic [INSTR_W-1:0] ir;
  logic [ADDR_W-1:0]  addrField;
  logic [DATA_W-1:0]  memData;
  logic [DATA_W-1:0]  aluY;
  logic [DATA_W-1:0]  cNext;

  assign opcode    = ir[INSTR_W-1:ADDR_W];
  assign addrField = ir[ADDR_W-1:0];

  mc16_dstore #(.AW(ADDR_W), .DW(DATA_W)) uStore (
    .addr  (addrField),
    .rdata (memData)
  );

  mc16_alu #(.W(DATA_W)) uAlu (
    .op (opcode),
    .a  (regA),
    .b  (regB),
    .y  (aluY)
  );

  assign cNext = strobe.selAlu ? aluY : memData;

  always_ff @(posedge clk) begin
    if (rst)                ir <= '0;
    else if (strobe.irLoad) ir <= imemData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regA <= '0;
      regB <= '0;
      regC <= '0;
    end else begin
      if (strobe.wrA) regA <= memData;
      if (strobe.wrB) regB <= memData;
      if (strobe.wrC) regC <= cNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                pc <= '0;
    else if (strobe.pcJump) pc <= addrField;
    else if (strobe.pcInc)  pc <= pc + 1'b1;
  end

  a_r1_state_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == '0 && regA == '0 && regB == '0 && regC == '0 && ir == '0));

  a_r3_ir_holds: assert property (@(posedge clk) disable iff (rst)
    !strobe.irLoad |=> $stable(ir));

  a_r4_load_a_from_store: assert property (@(posedge clk) disable iff (rst)
    strobe.wrA |=> regA == $past(memData));

  a_r5_jump_target: assert property (@(posedge clk) disable iff (rst)
    strobe.pcJump |=> (pc == $past(addrField) && $stable(regA) && $stable(regB) && $stable(regC)));

  a_r6_alu_keeps_operands: assert property (@(posedge clk) disable iff (rst)
    strobe.selAlu |=> ($stable(regA) && $stable(regB)));

  a_r8_pc_step: assert property (@(posedge clk) disable iff (rst)
    strobe.pcInc |=> pc == $past(pc) + 1'b1);

endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int OP_W   = 4,
  localparam int INSTR_W = OP_W + ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  output logic [ADDR_W-1:0]  imemAddr,
  input  logic [INSTR_W-1:0] imemData,
  output logic [DATA_W-1:0]  regA,
  output logic [DATA_W-1:0]  regB,
  output logic [DATA_W-1:0]  regC,
  output logic [ADDR_W-1:0]  pcOut
);

  dp_strobe_t        strobe;
  logic [OP_W-1:0]   opcode;
  logic [ADDR_W-1:0] pc;

  mc16_ctrl #(.OP_W(OP_W)) uCtrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .strobe (strobe)
  );

  mc16_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OP_W(OP_W)) uDp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .imemData (imemData),
    .opcode   (opcode),
    .pc       (pc),
    .regA     (regA),
    .regB     (regB),
    .regC     (regC)
  );

  assign imemAddr = pc;
  assign pcOut    = pc;

endmodule

// File: tb/tb_mc16_core.sv
`timescale 1ns/1ps
module tb_mc16_core;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] imemAddr;
  logic [15:0] imemData;
  logic [15:0] regA, regB, regC;
  logic [11:0] pcOut;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [15:0] aM, bM, cM;
  logic [11:0] pcM;

  always #2 clk = ~clk;

  mc16_core dut (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .regA(regA), .regB(regB), .regC(regC), .pcOut(pcOut)
  );

  function automatic logic [15:0] storeModel(input logic [11:0] a);
    logic [31:0] p;
    p = 32'(a) * 32'h9E37;
    return p[15:0];
  endfunction

  function automatic logic [15:0] aluModel(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
    logic [31:0] p;
    p = 32'(a) * 32'(b);
    case (op)
      4'b0000: return a + b;
      4'b0001: return p[15:0];
      4'b0010: return a - b;
      4'b0011: return (b == 16'd0) ? 16'hFFFF : a / b;
      4'b1000: return a & b;
      4'b1001: return a | b;
      4'b1010: return ~(a & b);
      4'b1011: return ~(a | b);
      4'b1100: return ~a;
      4'b1101: return ~b;
      4'b1110: return a ^ b;
      default: return ~(a ^ b);
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check(req, "regA", 32'(regA), 32'(aM));
    check(req, "regB", 32'(regB), 32'(bM));
    check(req, "regC", 32'(regC), 32'(cM));
    check(req, "pc",   32'(pcOut), 32'(pcM));
  endtask

  // called at a negedge in a load cycle; returns at the negedge of the next load cycle
  task automatic runInstr(input logic [15:0] instr);
    logic [3:0]  op;
    logic [11:0] ad;
    string tag;
    op = instr[15:12];
    ad = instr[11:0];
    check("R2", "imemAddr", 32'(imemAddr), 32'(pcM));
    imemData = instr;
    @(negedge clk);
    imemData = 16'($urandom);       // R3: scrambled during execute
    checkAll("R2");                 // nothing written yet
    @(negedge clk);
    case (op)
      4'b0100: begin aM = storeModel(ad); pcM = pcM + 12'd1; tag = "R4/R9"; end
      4'b0101: begin bM = storeModel(ad); pcM = pcM + 12'd1; tag = "R4/R9"; end
      4'b0110: begin cM = storeModel(ad); pcM = pcM + 12'd1; tag = "R4/R9"; end
      4'b0111: begin pcM = ad; tag = "R5"; end
      default: begin
        cM  = aluModel(op, aM, bM);
        pcM = pcM + 12'd1;
        tag = op[3] ? "R7" : "R6";
      end
    endcase
    checkAll(tag);
  endtask

  task automatic modelReset();
    aM = '0; bM = '0; cM = '0; pcM = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    imemData = 16'h4123;
    modelReset();
    repeat (3) @(negedge clk);
    checkAll("R1");
    check("R1", "imemAddr", 32'(imemAddr), 32'd0);
    rst = 1'b0;
    @(negedge clk);                  // reset-state cycle done, now in load
    checkAll("R1");                  // word on input during reset state ignored

    // division by zero: both operands from address 0 (R9: holds 0)
    runInstr({4'b0100, 12'h000});
    runInstr({4'b0101, 12'h000});
    runInstr({4'b0011, 12'h000});    // R6 0/0 -> FFFF
    runInstr({4'b0100, 12'h005});
    runInstr({4'b0011, 12'h000});    // R6 x/0 -> FFFF

    // every ALU code on nonzero operands
    runInstr({4'b0101, 12'h003});
    for (int k = 0; k < 16; k++) begin
      if (k < 4 || k > 7) runInstr({4'(k), 12'h000});
    end
    runInstr({4'b0110, 12'h7AB});    // R4 load C

    // R8 wrap via jump and increments
    runInstr({4'b0111, 12'hFFE});
    runInstr({4'b0000, 12'h000});
    runInstr({4'b1110, 12'h000});
    check("R8", "pc wrap", 32'(pcOut), 32'd0);
    runInstr({4'b0111, 12'hFFF});
    runInstr({4'b0110, 12'hFFF});
    check("R8", "pc wrap after load", 32'(pcOut), 32'd0);

    // R10: reset in the middle of an execute cycle
    runInstr({4'b0100, 12'h0A1});
    check("R2", "imemAddr", 32'(imemAddr), 32'(pcM));
    imemData = {4'b0101, 12'h0B2};
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    modelReset();
    checkAll("R10");
    rst = 1'b0;
    @(negedge clk);
    checkAll("R10");

    // R10: reset during a load cycle
    runInstr({4'b0100, 12'h0C3});
    imemData = {4'b0111, 12'h456};
    rst = 1'b1;
    @(negedge clk);
    modelReset();
    checkAll("R10");
    rst = 1'b0;
    @(negedge clk);

    // random instruction stream
    for (int n = 0; n < 600; n++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (w[15:12] == 4'b0111 && w[0]) w[15:12] = 4'b0100;
      runInstr(w);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule